// File: doc/BRIEF.md
# Block Lock Range Guard

This unit sits beside a flash array and decides, request by request, whether a program or erase aimed at a 12-bit block number may go ahead. It watches a byte-wide command/address input. From it, it picks out five command bytes: set range start, set range end, relock, freeze, and read lock status. It gathers the block number from the address cycles that follow.

Protection comes from one programmable block range. A flag can turn the range inside out, so that the range stays locked and everything outside it is released. A freeze state prevents any further change to that configuration. A lock-enable pin turns the whole scheme on or off. A write-protect pin, held low long enough, snaps the device back to fully locked.

Each request gets an allow/deny answer one cycle later. The status command returns a byte that describes the addressed block.

Top module: `blk_lock_guard`

## Requirements
- R1: After reset with `lock_pin_i` high, no block is unlocked: every request is denied and status reports locked. No response or status pulse is present after reset.
- R2: While `lock_pin_i` is low, every block counts as unlocked. Requests made with `wp_n_i` high are allowed, and status reports unlocked.
- R3: Command 23h followed by three address cycles stores the range start. Command 24h followed by three address cycles stores the range end and activates the range. The block number is byte 1 bits [7:0] as block[7:0] and byte 2 bits [3:0] as block[11:8]. Blocks from start to end inclusive become unlocked.
- R4: Bit 0 of the third address cycle of 24h is the invert flag. When it is set, blocks inside the range are locked and blocks outside it are unlocked.
- R5: Command 2Ah (no address) deactivates the range, which locks every block.
- R6: Command 2Ch (no address) enters the frozen state. After that, 23h, 24h and 2Ah have no effect, and status bit 2 reads 1.
- R7: When `wp_n_i` is sampled low on WP_CYC consecutive clock edges, the range is deactivated (all locked) and the frozen state is cleared. Any shorter low pulse changes no state.
- R8: A request presented while `wp_n_i` is low is denied, whatever the lock map says.
- R9: `resp_valid_o` pulses exactly one cycle after `req_valid_i`. `resp_allow_o` is never high without `resp_valid_o`.
- R10: Command 7Ah followed by three address cycles makes `stat_valid_o` pulse one cycle after the third cycle. `stat_byte_o` then holds bit 0 = unlocked, bit 1 = locked and bit 2 = frozen, with the other bits 0. Exactly one of bits 0 and 1 is set.
- R11: A range whose start is greater than its end contains no block. With invert set, it therefore unlocks every block.
- R12: A command byte arriving mid-sequence abandons the pending address sequence. Address cycles with no pending command have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_pin_i | input | 1 | Lock feature enable; low releases every block |
| wp_n_i | input | 1 | Active-low write protect |
| bus_valid_i | input | 1 | A byte is present on `bus_data_i` this cycle |
| bus_cmd_i | input | 1 | The present byte is a command |
| bus_addr_i | input | 1 | The present byte is an address cycle |
| bus_data_i | input | 8 | Command or address byte |
| req_valid_i | input | 1 | Program/erase permission request |
| req_blk_i | input | 12 | Target block of the request |
| resp_valid_o | output | 1 | Response to the previous cycle's request |
| resp_allow_o | output | 1 | Request may proceed |
| stat_valid_o | output | 1 | Status byte is valid |
| stat_byte_o | output | 8 | Lock status of the addressed block |

## Verification
The bench builds the block with its defaults: 12-bit block numbers, three address cycles and WP_CYC = 5. The five-edge write-protect window lets the bench reach both sides of the filter cheaply, with four-edge pulses that must be ignored and five-edge pulses that must relock. With a full 4096-block space, random ranges land on both ends of the array. Start-greater-than-end cases and the edges at start-1, start, end and end+1 are drawn often alongside directed checks of freeze, abort and lock-pin behaviour.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam logic [7:0] CMD_SET_LO  = 8'h23;
  localparam logic [7:0] CMD_SET_HI  = 8'h24;
  localparam logic [7:0] CMD_RELOCK  = 8'h2A;
  localparam logic [7:0] CMD_FREEZE  = 8'h2C;
  localparam logic [7:0] CMD_STATUS  = 8'h7A;

  localparam int ST_UNL_BIT = 0;
  localparam int ST_LCK_BIT = 1;
  localparam int ST_FRZ_BIT = 2;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SET_LO,
    OP_SET_HI,
    OP_STATUS
  } pend_op_e;
endpackage

// File: rtl/blk_lock_cmd_dec.sv
module blk_lock_cmd_dec
  import blk_lock_pkg::*;
#(
  parameter int BLK_W    = 12,
  parameter int ADDR_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid_i,
  input  logic             bus_cmd_i,
  input  logic             bus_addr_i,
  input  logic [7:0]       bus_data_i,
  output logic             do_relock_o,
  output logic             do_freeze_o,
  output logic             do_set_lo_o,
  output logic             do_set_hi_o,
  output logic             do_status_o,
  output logic [BLK_W-1:0] op_blk_o,
  output logic             op_inv_o
);
  localparam int CNT_W = $clog2(ADDR_CYC);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] HI_CNT   = CNT_W'(1);

  pend_op_e         op_q, op_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] blk_q;
  logic             cmd_hit, adr_hit, pend, final_cyc, cap_lo, cap_hi;

  always_comb begin
    cmd_hit   = bus_valid_i & bus_cmd_i;
    adr_hit   = bus_valid_i & bus_addr_i & ~bus_cmd_i;
    pend      = (op_q != OP_NONE);
    final_cyc = adr_hit & pend & (cnt_q == LAST_CNT);
    cap_lo    = adr_hit & pend & (cnt_q == '0);
    cap_hi    = adr_hit & pend & (cnt_q == HI_CNT);
    op_d      = op_q;
    cnt_d     = cnt_q;
    if (cmd_hit) begin
      cnt_d = '0;
      case (bus_data_i)
        CMD_SET_LO: op_d = OP_SET_LO;
        CMD_SET_HI: op_d = OP_SET_HI;
        CMD_STATUS: op_d = OP_STATUS;
        default:    op_d = OP_NONE;
      endcase
    end else if (final_cyc) begin
      op_d  = OP_NONE;
      cnt_d = '0;
    end else if (adr_hit & pend) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_NONE;
      cnt_q <= '0;
    end else begin
      op_q  <= op_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else begin
      if (cap_lo) blk_q[7:0] <= bus_data_i;
      if (cap_hi) blk_q[BLK_W-1:8] <= bus_data_i[BLK_W-9:0];
    end
  end

  assign do_relock_o = cmd_hit & (bus_data_i == CMD_RELOCK);
  assign do_freeze_o = cmd_hit & (bus_data_i == CMD_FREEZE);
  assign do_set_lo_o = final_cyc & (op_q == OP_SET_LO);
  assign do_set_hi_o = final_cyc & (op_q == OP_SET_HI);
  assign do_status_o = final_cyc & (op_q == OP_STATUS);
  assign op_blk_o    = blk_q;
  assign op_inv_o    = bus_data_i[0];
endmodule

// File: rtl/blk_lock_wp_filter.sv
module blk_lock_wp_filter #(
  parameter int WP_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n_i,
  output logic relock_o
);
  localparam int CW = $clog2(WP_CYC + 1);
  localparam logic [CW-1:0] SAT  = CW'(WP_CYC);
  localparam logic [CW-1:0] FIRE = CW'(WP_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wp_n_i)           cnt_d = '0;
    else if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign relock_o = ~wp_n_i & (cnt_q == FIRE);
endmodule

// File: rtl/blk_lock_state.sv
module blk_lock_state #(
  parameter int BLK_W = 12,
  parameter int NQ    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lock_pin_i,
  input  logic                      relock_i,
  input  logic                      do_relock_i,
  input  logic                      do_freeze_i,
  input  logic                      do_set_lo_i,
  input  logic                      do_set_hi_i,
  input  logic [BLK_W-1:0]          op_blk_i,
  input  logic                      op_inv_i,
  input  logic [NQ-1:0][BLK_W-1:0]  q_blk_i,
  output logic [NQ-1:0]             q_unl_o,
  output logic                      frozen_o
);
  logic [BLK_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic             inv_q, inv_d, act_q, act_d, frz_q, frz_d;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    inv_d = inv_q;
    act_d = act_q;
    frz_d = frz_q;
    if (relock_i) begin
      act_d = 1'b0;
      frz_d = 1'b0;
    end else begin
      if (do_freeze_i) frz_d = 1'b1;
      if (!frz_q) begin
        if (do_relock_i) act_d = 1'b0;
        if (do_set_lo_i) lo_d = op_blk_i;
        if (do_set_hi_i) begin
          hi_d  = op_blk_i;
          inv_d = op_inv_i;
          act_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      inv_q <= 1'b0;
      act_q <= 1'b0;
      frz_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      inv_q <= inv_d;
      act_q <= act_d;
      frz_q <= frz_d;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_query
    logic in_rng;
    assign in_rng     = (lo_q <= hi_q) && (q_blk_i[q] >= lo_q) && (q_blk_i[q] <= hi_q);
    assign q_unl_o[q] = ~lock_pin_i | (act_q & (in_rng ^ inv_q));
  end

  assign frozen_o = frz_q;
endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import blk_lock_pkg::*;
#(
  parameter int BLK_W    = 12,
  parameter int ADDR_CYC = 3,
  parameter int WP_CYC   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_pin_i,
  input  logic             wp_n_i,
  input  logic             bus_valid_i,
  input  logic             bus_cmd_i,
  input  logic             bus_addr_i,
  input  logic [7:0]       bus_data_i,
  input  logic             req_valid_i,
  input  logic [BLK_W-1:0] req_blk_i,
  output logic             resp_valid_o,
  output logic             resp_allow_o,
  output logic             stat_valid_o,
  output logic [7:0]       stat_byte_o
);
  localparam int NQ = 2;

  logic                     do_relock, do_freeze, do_set_lo, do_set_hi, do_status;
  logic [BLK_W-1:0]         op_blk;
  logic                     op_inv, wp_relock, lk_tight;
  logic [NQ-1:0][BLK_W-1:0] q_blk;
  logic [NQ-1:0]            q_unl;
  logic [7:0]               stat_d;
  logic                     allow_d;

  blk_lock_cmd_dec #(.BLK_W(BLK_W), .ADDR_CYC(ADDR_CYC)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .bus_valid_i(bus_valid_i), .bus_cmd_i(bus_cmd_i),
    .bus_addr_i(bus_addr_i), .bus_data_i(bus_data_i),
    .do_relock_o(do_relock), .do_freeze_o(do_freeze),
    .do_set_lo_o(do_set_lo), .do_set_hi_o(do_set_hi),
    .do_status_o(do_status), .op_blk_o(op_blk), .op_inv_o(op_inv)
  );

  blk_lock_wp_filter #(.WP_CYC(WP_CYC)) u_wp (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .relock_o(wp_relock)
  );

  assign q_blk[0] = req_blk_i;
  assign q_blk[1] = op_blk;

  blk_lock_state #(.BLK_W(BLK_W), .NQ(NQ)) u_state (
    .clk(clk), .rst_n(rst_n), .lock_pin_i(lock_pin_i),
    .relock_i(wp_relock), .do_relock_i(do_relock), .do_freeze_i(do_freeze),
    .do_set_lo_i(do_set_lo), .do_set_hi_i(do_set_hi),
    .op_blk_i(op_blk), .op_inv_i(op_inv),
    .q_blk_i(q_blk), .q_unl_o(q_unl), .frozen_o(lk_tight)
  );

  always_comb begin
    stat_d             = '0;
    stat_d[ST_UNL_BIT] = q_unl[1];
    stat_d[ST_LCK_BIT] = ~q_unl[1];
    stat_d[ST_FRZ_BIT] = lk_tight;
    allow_d            = req_valid_i & wp_n_i & q_unl[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_allow_o <= 1'b0;
      stat_valid_o <= 1'b0;
      stat_byte_o  <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_allow_o <= allow_d;
      stat_valid_o <= do_status;
      if (do_status) stat_byte_o <= stat_d;
    end
  end
endmodule

// File: rtl/blk_lock_guard_chk.sv
module blk_lock_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_pin_i,
  input logic       wp_n_i,
  input logic       req_valid_i,
  input logic       resp_valid_o,
  input logic       resp_allow_o,
  input logic       stat_valid_o,
  input logic [7:0] stat_byte_o,
  input logic       tight
);
  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> resp_valid_o); // R9
  AST_NO_STRAY_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid_o |-> !resp_allow_o); // R9
  AST_WP_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !wp_n_i) |=> !resp_allow_o); // R8
  AST_STAT_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> ($countones(stat_byte_o[1:0]) == 1)); // R10
  AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tight && wp_n_i) |=> tight); // R6
  AST_PIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && wp_n_i && !lock_pin_i) |=> resp_allow_o); // R2
endmodule

bind blk_lock_guard blk_lock_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lock_pin_i(lock_pin_i), .wp_n_i(wp_n_i),
  .req_valid_i(req_valid_i), .resp_valid_o(resp_valid_o),
  .resp_allow_o(resp_allow_o), .stat_valid_o(stat_valid_o),
  .stat_byte_o(stat_byte_o), .tight(lk_tight)
);

// File: tb/blk_lock_guard_bench.sv
module blk_lock_guard_bench;
  localparam int BLK_W  = 12;
  localparam int WP_CYC = 5;

  logic clk = 1'b0;
  logic rst_n, lock_pin, wp_n, bus_valid, bus_cmd, bus_addr, req_valid;
  logic [7:0] bus_data;
  logic [BLK_W-1:0] req_blk;
  logic resp_valid, resp_allow, stat_valid;
  logic [7:0] stat_byte;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int m_lo = 0, m_hi = 0;
  bit m_inv = 0, m_act = 0, m_frz = 0;

  always #10 clk = ~clk;

  blk_lock_guard #(.BLK_W(BLK_W), .ADDR_CYC(3), .WP_CYC(WP_CYC)) u_blk_lock_guard (
    .clk(clk), .rst_n(rst_n), .lock_pin_i(lock_pin), .wp_n_i(wp_n),
    .bus_valid_i(bus_valid), .bus_cmd_i(bus_cmd), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .req_valid_i(req_valid), .req_blk_i(req_blk),
    .resp_valid_o(resp_valid), .resp_allow_o(resp_allow),
    .stat_valid_o(stat_valid), .stat_byte_o(stat_byte)
  );

  function automatic bit exp_unl(input int b);
    bit inr;
    if (!lock_pin) return 1'b1;
    if (!m_act) return 1'b0;
    inr = (m_lo <= m_hi) && (b >= m_lo) && (b <= m_hi);
    return inr ^ m_inv;
  endfunction

  function automatic logic [7:0] exp_stat(input int b);
    bit u;
    u = exp_unl(b);
    return {5'b0, m_frz, ~u, u};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_byte(input bit is_cmd, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = is_cmd; bus_addr = !is_cmd; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_cmd = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic addr3(input int b, input bit inv);
    bus_byte(1'b0, 8'(b));
    bus_byte(1'b0, {4'h0, 4'(b >> 8)});
    bus_byte(1'b0, {7'h0, inv});
  endtask

  task automatic set_range(input int lo, input int hi, input bit inv);
    bus_byte(1'b1, 8'h23); addr3(lo, 1'b0);
    if (!m_frz) m_lo = lo;
    bus_byte(1'b1, 8'h24); addr3(hi, inv);
    if (!m_frz) begin m_hi = hi; m_inv = inv; m_act = 1'b1; end
  endtask

  task automatic relock_cmd();
    bus_byte(1'b1, 8'h2A);
    if (!m_frz) m_act = 1'b0;
  endtask

  task automatic freeze_cmd();
    bus_byte(1'b1, 8'h2C);
    m_frz = 1'b1;
  endtask

  task automatic query(input string tag, input int b);
    @(negedge clk);
    req_valid = 1'b1; req_blk = BLK_W'(b);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " resp_valid (R9)"}, resp_valid, 1);
    check({tag, " allow"}, resp_allow, exp_unl(b) & wp_n);
  endtask

  task automatic status(input string tag, input int b);
    bus_byte(1'b1, 8'h7A);
    addr3(b, 1'b0);
    check({tag, " stat_valid (R10)"}, stat_valid, 1);
    check({tag, " stat_byte (R10)"}, stat_byte, exp_stat(b));
  endtask

  // n edges low (n >= 2); a request is made on the first low cycle
  task automatic wp_pulse(input int n, input int b);
    @(negedge clk);
    wp_n = 1'b0; req_valid = 1'b1; req_blk = BLK_W'(b);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 deny while wp low", resp_allow, 0);
    repeat (n - 2) @(negedge clk);
    @(negedge clk);
    wp_n = 1'b1;
    if (n >= WP_CYC) begin m_act = 1'b0; m_frz = 1'b0; end
  endtask

  function automatic int pick_blk();
    int b;
    case ($urandom_range(0, 3))
      0: b = int'($urandom_range(0, 4095));
      1: b = m_lo + int'($urandom_range(0, 2)) - 1;
      2: b = m_hi + int'($urandom_range(0, 2)) - 1;
      default: b = $urandom_range(0, 1) ? 4095 : 0;
    endcase
    return b & 32'hFFF;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; lock_pin = 1'b1; wp_n = 1'b1;
    bus_valid = 1'b0; bus_cmd = 1'b0; bus_addr = 1'b0; bus_data = '0;
    req_valid = 1'b0; req_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid after reset", resp_valid, 0);
    check("R1 stat_valid after reset", stat_valid, 0);
    query("R1 block 0", 0);
    query("R1 block 4095", 4095);
    status("R1 status", 77);

    set_range(100, 200, 1'b0);
    query("R3 below start", 99);
    query("R3 at start", 100);
    query("R3 at end", 200);
    query("R3 above end", 201);
    status("R3 status inside", 150);

    set_range(100, 200, 1'b1);
    query("R4 inside inverted", 150);
    query("R4 outside low", 99);
    query("R4 outside top", 4095);

    relock_cmd();
    query("R5 after relock", 99);

    set_range(300, 200, 1'b0);
    query("R11 empty range", 250);
    set_range(300, 200, 1'b1);
    query("R11 empty inverted", 250);

    // R12: abort a pending start sequence, stray address cycles ignored
    set_range(10, 20, 1'b0);
    bus_byte(1'b1, 8'h23);
    bus_byte(1'b0, 8'd15);
    bus_byte(1'b1, 8'h00);
    bus_byte(1'b0, 8'd0);
    bus_byte(1'b0, 8'd0);
    bus_byte(1'b0, 8'd0);
    query("R12 start unchanged", 10);
    query("R12 below start", 9);
    bus_byte(1'b1, 8'h24);
    bus_byte(1'b0, 8'd30);
    bus_byte(1'b1, 8'h70);
    bus_byte(1'b0, 8'd0);
    bus_byte(1'b0, 8'd0);
    query("R12 end unchanged", 21);

    wp_pulse(WP_CYC - 1, 12);
    query("R7 short pulse ignored", 12);
    wp_pulse(WP_CYC, 12);
    query("R7 long pulse relocks", 12);

    set_range(0, 4095, 1'b0);
    freeze_cmd();
    relock_cmd();
    query("R6 relock ignored when frozen", 500);
    set_range(5, 6, 1'b1);
    query("R6 range ignored when frozen", 500);
    status("R6 frozen status", 500);
    wp_pulse(WP_CYC, 1);
    query("R7 wp clears freeze and locks", 500);
    status("R7 status after wp", 500);

    lock_pin = 1'b0;
    query("R2 pin low allows", 321);
    status("R2 pin low status", 321);
    lock_pin = 1'b1;

    for (int i = 0; i < 500; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 20) begin
        int lo, hi;
        lo = int'($urandom_range(0, 4095));
        hi = $urandom_range(0, 3) == 0 ? int'($urandom_range(0, 4095))
                                       : ((lo + int'($urandom_range(0, 300))) & 32'hFFF);
        set_range(lo, hi, 1'($urandom_range(0, 1)));
      end else if (r < 25) relock_cmd();
      else if (r < 27) freeze_cmd();
      else if (r < 32) wp_pulse(int'($urandom_range(2, 2 * WP_CYC)), pick_blk());
      else if (r < 70) query("R3/R4/R11 random", pick_blk());
      else status("R10 random", pick_blk());
    end

    finish_run();
  end
endmodule